// File: doc/BRIEF.md
# Serial Burst Inter-Byte Interval Controller

This block sets the idle gap between consecutive bytes of an automatic multi-byte serial transfer that runs from an internally generated serial clock. A small shifter moves each byte out on `sdo`, most significant bit first, and takes a byte in from `sdi` at the same time. When a byte completes, the block snapshots the current CPU activity code and the programmed interval settings. It then counts CPU-clock ticks and serial half-period ticks until the required gap has passed. At that point it emits a one-cycle `start_next` strobe and starts the next byte from `tx_byte` on the same edge.

Two kinds of delay set the gap, and the longer one decides. The first is a floor of two and a half serial-clock periods (five half-period ticks). The second is a CPU cycle count, and the activity code picks that count. When the interval-enable input is set, the serial-side requirement rises to twice the programmed count in half-period ticks if that is larger than the floor. All of this applies only while internal-clock mode is selected. Dropping that mode input returns the block to idle at once.

Top module: `sbi_gap_ctrl`

## Requirements
- R1: After `go` in internal-clock mode, the byte on `tx_byte` goes out on `sdo` MSB first. `sck` idles high, falls on the first half tick of each bit and rises on the second, so a byte takes 16 half ticks and `sdo` changes only as `sck` rises.
- R2: `sdi` is sampled on each rising `sck`. On the eighth rise, `rx_byte` holds the received byte with the first bit in position 7, and `byte_done` pulses high for exactly one cycle.
- R3: The CPU requirement comes from `op_kind`: 0 (other) needs 7 CPU ticks, 1 (multiply) needs 13, 2 (divide) needs 20 and 3 (external access with one wait) needs 9.
- R4: A gap never ends before five serial half ticks have been counted, whatever the other settings are.
- R5: With `ivl_en` = 1 the serial requirement is max(5, 2·`ivl_count`) half ticks. With `ivl_en` = 0, `ivl_count` has no effect.
- R6: Ticks are counted from the cycle after `byte_done`. `start_next` is a one-cycle pulse in the cycle after both requirements are first met, and on that same edge the next byte is loaded, with its first bit on `sdo`.
- R7: `op_kind`, `ivl_en` and `ivl_count` are captured in the `byte_done` cycle. Changes to them during the gap do not change its length.
- R8: While `int_clk_mode` = 0, `go` is ignored. Any byte or gap in progress is abandoned: `sck` returns high and neither `byte_done` nor `start_next` is produced.
- R9: After reset, `sck` = 1, `sdo` = 0, `rx_byte` = 0, and `byte_done` and `start_next` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_clk_mode | input | 1 | 1 selects internal-clock automatic operation |
| go | input | 1 | Starts the first byte of a burst from idle |
| cpu_tick | input | 1 | One pulse per CPU clock period |
| sck_half_tick | input | 1 | One pulse per serial half period |
| op_kind | input | 2 | CPU activity code (R3) |
| ivl_en | input | 1 | Enables the programmed interval |
| ivl_count | input | 7 | Programmed interval in serial periods |
| tx_byte | input | 8 | Byte to send |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock out |
| sdo | output | 1 | Serial data out |
| rx_byte | output | 8 | Last received byte |
| byte_done | output | 1 | One-cycle pulse at byte end |
| start_next | output | 1 | One-cycle pulse when the gap ends |

## Verification
A CPU tick and a serial half tick can arrive in the same cycle. The bench provokes this with tick periods that share factors, or that are equal. Because each tick counts toward its own requirement, the bench judges every gap by the tick counts it drove itself: both counts must reach their requirement, and at least one must equal its requirement exactly when `start_next` appears. The second coincidence is a gap ending on the same edge that loads the next byte. That is judged by finding the new byte's first bit on `sdo` in the strobe cycle, and by a late change of the activity and interval settings that must not alter the measured gap.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

   typedef enum logic [1:0] {
      OP_PLAIN = 2'd0,
      OP_MUL   = 2'd1,
      OP_DIV   = 2'd2,
      OP_EXTW  = 2'd3
   } sbi_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } sbi_state_e;

   function automatic int sbi_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int sbi_min(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/sbi_byte_shifter.sv
module sbi_byte_shifter #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              abort,
   input  logic              half_tick,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              sdi,
   output logic              sck,
   output logic              sdo,
   output logic [DATA_W-1:0] rx_data,
   output logic              done
);
   localparam int BIT_W = $clog2(DATA_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("sbi_byte_shifter: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] tx_sh, rx_sh, rx_q, tx_nxt, rx_nxt;
   logic [BIT_W-1:0]  bit_q;
   logic              active_q, sck_q, done_q;

   if (MSB_FIRST) begin : g_msb
      assign tx_nxt = {tx_sh[DATA_W-2:0], 1'b0};
      assign rx_nxt = {rx_sh[DATA_W-2:0], sdi};
      assign sdo    = tx_sh[DATA_W-1];
   end else begin : g_lsb
      assign tx_nxt = {1'b0, tx_sh[DATA_W-1:1]};
      assign rx_nxt = {sdi, rx_sh[DATA_W-1:1]};
      assign sdo    = tx_sh[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh    <= '0;
         rx_sh    <= '0;
         rx_q     <= '0;
         bit_q    <= '0;
         active_q <= 1'b0;
         sck_q    <= 1'b1;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            active_q <= 1'b0;
            sck_q    <= 1'b1;
         end else if (load) begin
            tx_sh    <= tx_data;
            bit_q    <= '0;
            active_q <= 1'b1;
            sck_q    <= 1'b1;
         end else if (active_q && half_tick) begin
            if (sck_q) begin
               sck_q <= 1'b0;
            end else begin
               sck_q <= 1'b1;
               rx_sh <= rx_nxt;
               if (bit_q == LAST_BIT) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
                  rx_q     <= rx_nxt;
               end else begin
                  tx_sh <= tx_nxt;
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   assign sck     = sck_q;
   assign rx_data = rx_q;
   assign done    = done_q;

   // R1: the serial clock rests high whenever no byte is moving
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> sck_q);

   // R2: the completion flag never lasts two cycles
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R1: a byte ends only from its last bit position
   a_r1_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (bit_q == LAST_BIT));

endmodule

// File: rtl/sbi_gap_timer.sv
module sbi_gap_timer
   import sbi_pkg::*;
#(
   parameter int IVL_W      = 7,
   parameter int FLOOR_HALF = 5,
   parameter int N_PLAIN    = 7,
   parameter int N_MUL      = 13,
   parameter int N_DIV      = 20,
   parameter int N_EXTW     = 9,
   parameter int CPU_W      = 5,
   parameter int HALF_W     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              clear,
   input  logic              run,
   input  logic [1:0]        op_in,
   input  logic              en_in,
   input  logic [IVL_W-1:0]  ivl_in,
   input  logic              cpu_tick,
   input  logic              half_tick,
   output logic              met,
   output logic [CPU_W-1:0]  cpu_cnt,
   output logic [HALF_W-1:0] half_cnt
);
   localparam logic [CPU_W-1:0]  CPU_SAT  = '1;
   localparam logic [HALF_W-1:0] HALF_SAT = '1;
   localparam logic [HALF_W-1:0] FLOOR_V  = HALF_W'(FLOOR_HALF);

   if (FLOOR_HALF < 1 || FLOOR_HALF >= (1 << HALF_W)) begin : g_bad_floor
      $error("sbi_gap_timer: FLOOR_HALF out of range");
   end
   if (HALF_W < IVL_W + 1) begin : g_bad_half_w
      $error("sbi_gap_timer: HALF_W too narrow for doubled interval");
   end
   if (N_PLAIN < 1 || N_MUL < 1 || N_DIV < 1 || N_EXTW < 1) begin : g_bad_n
      $error("sbi_gap_timer: CPU cycle counts must be positive");
   end

   sbi_op_e            op_q;
   logic               en_q;
   logic [IVL_W-1:0]   ivl_q;
   logic [CPU_W-1:0]   need_cpu;
   logic [HALF_W-1:0]  need_half, dbl_ivl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_PLAIN;
         en_q  <= 1'b0;
         ivl_q <= '0;
      end else if (capture) begin
         op_q  <= sbi_op_e'(op_in);
         en_q  <= en_in;
         ivl_q <= ivl_in;
      end
   end

   always_comb begin
      unique case (op_q)
         OP_MUL:  need_cpu = CPU_W'(N_MUL);
         OP_DIV:  need_cpu = CPU_W'(N_DIV);
         OP_EXTW: need_cpu = CPU_W'(N_EXTW);
         default: need_cpu = CPU_W'(N_PLAIN);
      endcase
   end

   assign dbl_ivl   = HALF_W'({ivl_q, 1'b0});
   assign need_half = (en_q && (dbl_ivl > FLOOR_V)) ? dbl_ivl : FLOOR_V;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_cnt  <= '0;
         half_cnt <= '0;
      end else if (clear) begin
         cpu_cnt  <= '0;
         half_cnt <= '0;
      end else if (run) begin
         if (cpu_tick && (cpu_cnt != CPU_SAT))
            cpu_cnt <= cpu_cnt + 1'b1;
         if (half_tick && (half_cnt != HALF_SAT))
            half_cnt <= half_cnt + 1'b1;
      end
   end

   assign met = run && (cpu_cnt >= need_cpu) && (half_cnt >= need_half);

   // R7: the snapshot stays put for the whole gap
   a_r7_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !capture) |=> ($stable(op_q) && $stable(en_q) && $stable(ivl_q)));

   // R6: counters advance only while the gap is running
   a_r6_count_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> ($stable(cpu_cnt) && $stable(half_cnt)));

endmodule

// File: rtl/sbi_gap_ctrl.sv
module sbi_gap_ctrl
   import sbi_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int IVL_W      = 7,
   parameter int FLOOR_HALF = 5,
   parameter int N_PLAIN    = 7,
   parameter int N_MUL      = 13,
   parameter int N_DIV      = 20,
   parameter int N_EXTW     = 9,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_clk_mode,
   input  logic              go,
   input  logic              cpu_tick,
   input  logic              sck_half_tick,
   input  logic [1:0]        op_kind,
   input  logic              ivl_en,
   input  logic [IVL_W-1:0]  ivl_count,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              sdi,
   output logic              sck,
   output logic              sdo,
   output logic [DATA_W-1:0] rx_byte,
   output logic              byte_done,
   output logic              start_next
);
   localparam int N_MAX  = sbi_max(sbi_max(N_PLAIN, N_MUL), sbi_max(N_DIV, N_EXTW));
   localparam int N_MIN  = sbi_min(sbi_min(N_PLAIN, N_MUL), sbi_min(N_DIV, N_EXTW));
   localparam int CPU_W  = $clog2(N_MAX + 1);
   localparam int HALF_W = sbi_max(IVL_W + 2, $clog2(FLOOR_HALF + 1));

   sbi_state_e         st_q;
   logic               launch, done_w, met_w, run_w, start_q;
   logic [CPU_W-1:0]   cpu_cnt_w;
   logic [HALF_W-1:0]  half_cnt_w;

   assign run_w  = int_clk_mode && (st_q == ST_GAP);
   assign launch = int_clk_mode &&
                   (((st_q == ST_IDLE) && go) || ((st_q == ST_GAP) && met_w));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         start_q <= 1'b0;
      end else if (!int_clk_mode) begin
         st_q    <= ST_IDLE;
         start_q <= 1'b0;
      end else begin
         start_q <= (st_q == ST_GAP) && met_w;
         unique case (st_q)
            ST_IDLE:  if (go)     st_q <= ST_SHIFT;
            ST_SHIFT: if (done_w) st_q <= ST_GAP;
            ST_GAP:   if (met_w)  st_q <= ST_SHIFT;
            default:              st_q <= ST_IDLE;
         endcase
      end
   end

   sbi_byte_shifter #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (launch),
      .abort     (!int_clk_mode),
      .half_tick (sck_half_tick),
      .tx_data   (tx_byte),
      .sdi       (sdi),
      .sck       (sck),
      .sdo       (sdo),
      .rx_data   (rx_byte),
      .done      (done_w)
   );

   sbi_gap_timer #(
      .IVL_W      (IVL_W),
      .FLOOR_HALF (FLOOR_HALF),
      .N_PLAIN    (N_PLAIN),
      .N_MUL      (N_MUL),
      .N_DIV      (N_DIV),
      .N_EXTW     (N_EXTW),
      .CPU_W      (CPU_W),
      .HALF_W     (HALF_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   ((st_q == ST_SHIFT) && done_w),
      .clear     (launch || !int_clk_mode),
      .run       (run_w),
      .op_in     (op_kind),
      .en_in     (ivl_en),
      .ivl_in    (ivl_count),
      .cpu_tick  (cpu_tick),
      .half_tick (sck_half_tick),
      .met       (met_w),
      .cpu_cnt   (cpu_cnt_w),
      .half_cnt  (half_cnt_w)
   );

   assign byte_done  = done_w;
   assign start_next = start_q;

   // R6: the strobe is a single-cycle pulse
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start_next |=> !start_next);

   // R8: nothing is signalled once internal-clock mode is off
   a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !int_clk_mode |=> (!start_next && !byte_done));

   // R4: the serial floor was reached before the gap ended
   a_r4_floor_met: assert property (@(posedge clk) disable iff (!rst_n)
      start_next |-> ($past(half_cnt_w) >= HALF_W'(FLOOR_HALF)));

   // R3: the smallest CPU requirement was reached before the gap ended
   a_r3_cpu_min: assert property (@(posedge clk) disable iff (!rst_n)
      start_next |-> ($past(cpu_cnt_w) >= CPU_W'(N_MIN)));

   // R2: a finished byte always leads into a gap
   a_r2_done_to_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && int_clk_mode) |=> (st_q == ST_GAP));

endmodule

// File: tb/test_sbi_gap_ctrl.sv
module test_sbi_gap_ctrl;

   typedef struct packed {
      logic [1:0] op;
      logic       en;
      logic [6:0] ivl;
      logic [3:0] cper;
      logic [3:0] hper;
      logic [7:0] tx;
      logic [1:0] late;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{op:2'd0, en:1'b0, ivl:7'd0,   cper:4'd2, hper:4'd3, tx:8'hA5, late:2'd2},
      '{op:2'd1, en:1'b0, ivl:7'd50,  cper:4'd2, hper:4'd3, tx:8'h3C, late:2'd0},
      '{op:2'd2, en:1'b0, ivl:7'd0,   cper:4'd2, hper:4'd3, tx:8'h81, late:2'd0},
      '{op:2'd3, en:1'b0, ivl:7'd0,   cper:4'd3, hper:4'd2, tx:8'h7E, late:2'd2},
      '{op:2'd0, en:1'b1, ivl:7'd2,   cper:4'd3, hper:4'd2, tx:8'hC3, late:2'd2},
      '{op:2'd0, en:1'b1, ivl:7'd3,   cper:4'd2, hper:4'd3, tx:8'h5A, late:2'd1},
      '{op:2'd1, en:1'b1, ivl:7'd20,  cper:4'd2, hper:4'd2, tx:8'hF0, late:2'd2},
      '{op:2'd2, en:1'b1, ivl:7'd127, cper:4'd2, hper:4'd2, tx:8'h0F, late:2'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic int_clk_mode = 1'b0, go = 1'b0, cpu_tick = 1'b0, sck_half_tick = 1'b0;
   logic [1:0] op_kind = 2'd0;
   logic ivl_en = 1'b0;
   logic [6:0] ivl_count = '0;
   logic [7:0] tx_byte = '0;
   logic sdi, sck, sdo, byte_done, start_next;
   logic [7:0] rx_byte;

   int checks = 0, failures = 0;
   int cper = 3, hper = 4, tcyc = 0;
   int n_done = 0, n_start = 0, sck_low_seen = 0;
   int exp_n = 7, exp_h = 5;
   logic [7:0] tx_cur = '0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign sdi = ~sdo;

   sbi_gap_ctrl i_sbi_gap_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .int_clk_mode  (int_clk_mode),
      .go            (go),
      .cpu_tick      (cpu_tick),
      .sck_half_tick (sck_half_tick),
      .op_kind       (op_kind),
      .ivl_en        (ivl_en),
      .ivl_count     (ivl_count),
      .tx_byte       (tx_byte),
      .sdi           (sdi),
      .sck           (sck),
      .sdo           (sdo),
      .rx_byte       (rx_byte),
      .byte_done     (byte_done),
      .start_next    (start_next)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int n_for(input logic [1:0] op);
      case (op)
         2'd1: return 13;
         2'd2: return 20;
         2'd3: return 9;
         default: return 7;
      endcase
   endfunction

   function automatic int h_for(input logic en, input logic [6:0] ivl);
      if (en && (2 * int'(ivl) > 5)) return 2 * int'(ivl);
      return 5;
   endfunction

   // tick generator: ticks change just after the rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         tcyc++;
         cpu_tick      = (tcyc % cper) == 0;
         sck_half_tick = (tcyc % hper) == 0;
      end
   end

   // monitor: judges data, pulses and gap lengths from the ports
   initial begin
      bit armed = 1'b0, prev_done = 1'b0, sck_prev = 1'b1;
      logic sdo_low = 1'b0;
      logic [7:0] cap = '0;
      int ncap = 0, gc = 0, gh = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (!sck) begin
               sdo_low = sdo;
               sck_low_seen++;
            end
            if (sck && !sck_prev) begin
               cap = {cap[6:0], sdo_low};
               ncap++;
            end
            sck_prev = sck;
            if (!int_clk_mode) begin
               armed = 1'b0;
               cap   = '0;
               ncap  = 0;
            end
            if (byte_done) begin
               n_done++;
               check(!prev_done, "R2 byte_done single cycle", 1, 0);
               check(ncap == 8 && cap == tx_cur, "R1 MSB-first bits on sdo", int'(cap), int'(tx_cur));
               check(rx_byte == ~tx_cur, "R2 received byte", int'(rx_byte), int'(~tx_cur));
               cap = '0; ncap = 0;
               armed = 1'b1; gc = 0; gh = 0;
            end else if (start_next) begin
               n_start++;
               check(armed, "R6 strobe only after a byte", 0, 1);
               // R3 R4 R5: both needs met, and the last tick made one of them exact
               check(gc >= exp_n && gh >= exp_h && (gc == exp_n || gh == exp_h),
                     "R3 R4 R5 gap cpu ticks", gc, exp_n);
               check(gh >= exp_h, "R4 R5 gap half ticks", gh, exp_h);
               check(sdo == tx_cur[7], "R6 next byte loaded with strobe", int'(sdo), int'(tx_cur[7]));
               armed = 1'b0;
            end else if (armed) begin
               gc += int'(cpu_tick);
               gh += int'(sck_half_tick);
            end
            prev_done = byte_done;
         end
      end
   end

   task automatic pulse_go();
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
   endtask

   task automatic wait_done(input int target, input string req);
      int k = 0;
      while (n_done < target && k < 4000) begin
         @(negedge clk);
         k++;
      end
      check(n_done >= target, req, n_done, target);
   endtask

   task automatic wait_start(input int target, input string req);
      int k = 0;
      while (n_start < target && k < 4000) begin
         @(negedge clk);
         k++;
      end
      check(n_start >= target, req, n_start, target);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9: reset state
      check(sck == 1'b1, "R9 sck after reset", int'(sck), 1);
      check(sdo == 1'b0, "R9 sdo after reset", int'(sdo), 0);
      check(rx_byte == 8'h00, "R9 rx_byte after reset", int'(rx_byte), 0);
      check(byte_done == 1'b0, "R9 byte_done after reset", int'(byte_done), 0);
      check(start_next == 1'b0, "R9 start_next after reset", int'(start_next), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // table walk: each vector runs two bytes and one measured gap
      for (int v = 0; v < NV; v++) begin
         vec_t t;
         int bd, bs;
         t = VEC[v];
         op_kind   = t.op;
         ivl_en    = t.en;
         ivl_count = t.ivl;
         cper      = int'(t.cper);
         hper      = int'(t.hper);
         tx_byte   = t.tx;
         tx_cur    = t.tx;
         exp_n     = n_for(t.op);
         exp_h     = h_for(t.en, t.ivl);
         bd = n_done;
         bs = n_start;
         int_clk_mode = 1'b1;
         pulse_go();
         wait_done(bd + 1, "R1 first byte completes");
         // R7: settings change after capture must not alter the gap
         @(posedge clk); #2;
         op_kind   = t.late;
         ivl_en    = 1'b1;
         ivl_count = 7'd127;
         wait_start(bs + 1, "R6 gap ends with a strobe");
         wait_done(bd + 2, "R6 second byte completes");
         @(negedge clk);
         int_clk_mode = 1'b0;
         repeat (3) @(negedge clk);
      end

      // R8: go ignored while internal-clock mode is off
      begin
         int low0, d0;
         cper = 3; hper = 2;
         low0 = sck_low_seen;
         d0   = n_done;
         int_clk_mode = 1'b0;
         pulse_go();
         repeat (60) @(negedge clk);
         check(sck_low_seen == low0, "R8 no serial clock with mode off", sck_low_seen - low0, 0);
         check(n_done == d0, "R8 no byte with mode off", n_done, d0);
      end

      // R8: abandoning a byte in flight
      begin
         int d0, s0;
         tx_byte = 8'h96;
         tx_cur  = 8'h96;
         int_clk_mode = 1'b1;
         d0 = n_done;
         s0 = n_start;
         pulse_go();
         repeat (13) @(negedge clk);
         int_clk_mode = 1'b0;
         repeat (2) @(negedge clk);
         check(sck == 1'b1, "R8 sck high after abandon", int'(sck), 1);
         repeat (80) @(negedge clk);
         check(n_done == d0, "R8 no byte_done after abandon", n_done, d0);
         check(n_start == s0, "R8 no start_next after abandon", n_start, s0);
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule